// File: doc/BRIEF.md
# Four-Phase Asynchronous SRAM Access Sequencer

This block connects a synchronous CPU-side request port to an asynchronous static RAM. It runs on a phase clock four times faster than the CPU clock, so each CPU clock period contains four phase-clock cycles. Every access is spread across these four phases. The address, the data, the byte strobes and the bus direction are set up first. The write strobe is pulsed only in the two inner phases. The final phase holds everything steady with the write strobe already released. As a result, the SRAM never sees an address or data change while a write is open.

An alignment strobe `cpu_edge` is high for one phase-clock cycle, and the phase-clock edge that samples it is the CPU clock edge. At that edge the request (`req_valid`, `req_write`, `req_addr`, `req_wdata`, `req_be`) is taken, and the next four phase-clock cycles are phases 0 to 3 of the access. Sampling the strobe also forces the phase counter back to phase 0. This keeps the sequencer locked to the CPU clock wherever the counter happened to be. The SRAM data bus is given as separate out, in and drive-enable signals so the tri-state buffer can sit at the pad.

Top module: `sram_phase_ctrl`

## Requirements
- R1: While reset is high and right after it, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0 and every bit of sram_be_n is 1.
- R2: A request sampled together with cpu_edge appears on sram_addr in the next phase-clock cycle (phase 0) and stays unchanged through phase 3.
- R3: For a write, sram_we_n is 0 in phases 1 and 2 only and 1 in phases 0 and 3. For a read it stays 1 throughout.
- R4: sram_addr, sram_dq_out, sram_be_n, sram_oe_n and sram_dq_oe do not change in the cycle before sram_we_n falls, while it is 0, or in the cycle after it rises.
- R5: For a write, sram_dq_oe is 1 and sram_oe_n is 1 for all four phases, and sram_dq_out carries the request data.
- R6: For a read, sram_oe_n is 0 for all four phases and sram_dq_oe is 0. The two are never active together.
- R7: For a read, sram_dq_in is captured at the end of phase 2. It is presented on rd_data from phase 3 and held until the next read capture.
- R8: If cpu_edge comes with req_valid low, or if no cpu_edge follows phase 3, the next cycles are idle: sram_we_n=1, sram_oe_n=1, sram_dq_oe=0, sram_be_n all ones, and the SRAM contents are left untouched.
- R9: sram_be_n is the active-low copy of req_be. Bit i strobes data bits [8i+7:8i]. A byte whose bit is 0 in req_be is not written.
- R10: cpu_edge restarts the sequence at phase 0 from any counter position, including after idle gaps of any length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, four times the CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_edge | input | 1 | High one phase cycle; its sampling edge is the CPU clock edge |
| req_valid | input | 1 | Access requested for this CPU cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Active-high byte enables |
| rd_data | output | DATA_W | Read data returned to the CPU |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq_out | output | DATA_W | Data driven onto the SRAM bus |
| sram_dq_in | input | DATA_W | Data read from the SRAM bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_be_n | output | DATA_W/8 | Active-low byte strobes |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |

## Verification
The bench writes every address of a 16-word configuration with a computed pattern and reads it back. It then sweeps all four byte-enable combinations, the empty one included. A design with a masking or polarity mistake would corrupt or miss bytes, and the bench's arithmetic model of memory would catch that in the read-back. A monitor compares every SRAM control and data output in the cycles around each write pulse. A pulse that is one phase too wide or placed one phase early would show up as a change while the write is open. The bench also inserts idle gaps of one to three cycles before accesses and issues CPU cycles with no request. A counter that does not resynchronise, or that drives the bus while idle, then shows wrong phase-0 timing or active strobes.

// File: rtl/sram_phase_pkg.sv
package sram_phase_pkg;

    // Position inside one CPU cycle; the order is the access sequence.
    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_WR_A  = 2'd1,
        PH_WR_B  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    // Latched kind of the access in progress.
    typedef struct packed {
        logic act;
        logic wr;
    } acc_ctl_t;

    localparam acc_ctl_t ACC_IDLE = '{act: 1'b0, wr: 1'b0};

    // Phases in which the write strobe may be low.
    function automatic logic strobe_phase(input phase_e p);
        return (p == PH_WR_A) || (p == PH_WR_B);
    endfunction

    function automatic phase_e phase_after(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_phase_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cpu_edge,
    output phase_e ph
);

    always_ff @(posedge clk) begin
        if (rst)
            ph <= PH_HOLD;
        else if (cpu_edge)
            ph <= PH_SETUP;
        else
            ph <= phase_after(ph);
    end

endmodule

// File: rtl/sram_phase_drv.sv
module sram_phase_drv
    import sram_phase_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_edge,
    input  phase_e            ph,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic [BE_W-1:0]   sram_be_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    acc_ctl_t ctl;
    logic     open_wr;
    logic     rd_grab;

    // Strobe for the coming phase; aborted by a new CPU edge.
    assign open_wr = !cpu_edge && ctl.act && ctl.wr && strobe_phase(phase_after(ph));
    assign rd_grab = !cpu_edge && ctl.act && !ctl.wr && (ph == PH_WR_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl         <= ACC_IDLE;
            sram_addr   <= '0;
            sram_dq_out <= '0;
            sram_be_n   <= '1;
            sram_oe_n   <= 1'b1;
            sram_dq_oe  <= 1'b0;
            sram_we_n   <= 1'b1;
            rd_data     <= '0;
        end else begin
            if (cpu_edge) begin
                ctl         <= '{act: req_valid, wr: req_write};
                sram_addr   <= req_addr;
                sram_dq_out <= req_wdata;
                sram_be_n   <= req_valid ? ~req_be : '1;
                sram_oe_n   <= !(req_valid && !req_write);
                sram_dq_oe  <= req_valid && req_write;
            end else if (ph == PH_HOLD) begin
                ctl        <= ACC_IDLE;
                sram_be_n  <= '1;
                sram_oe_n  <= 1'b1;
                sram_dq_oe <= 1'b0;
            end
            sram_we_n <= !open_wr;
            if (rd_grab)
                rd_data <= sram_dq_in;
        end
    end

    // R3
    we_inner_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> strobe_phase(ph));

    // R5
    we_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_dq_oe && sram_oe_n));

    // R4
    we_stable_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_be_n)));

    // R6
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(sram_dq_oe && !sram_oe_n));

    // R8
    idle_be_chk: assert property (@(posedge clk) disable iff (rst)
        (sram_oe_n && !sram_dq_oe) |-> (&sram_be_n));

endmodule

// File: rtl/sram_phase_ctrl.sv
module sram_phase_ctrl
    import sram_phase_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_edge,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic [BE_W-1:0]   sram_be_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    phase_e ph;

    sram_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cpu_edge (cpu_edge),
        .ph       (ph)
    );

    sram_phase_drv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_drv (
        .clk         (clk),
        .rst         (rst),
        .cpu_edge    (cpu_edge),
        .ph          (ph),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .sram_dq_in  (sram_dq_in),
        .rd_data     (rd_data),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_be_n   (sram_be_n),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n)
    );

    // R10
    edge_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_edge |=> (ph == PH_SETUP));

endmodule

// File: tb/sram_phase_ctrl_test.sv
module sram_phase_ctrl_test;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = DW / 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_edge = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in;
    logic          sram_dq_oe;
    logic [BW-1:0] sram_be_n;
    logic          sram_oe_n;
    logic          sram_we_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] model [WORDS];

    always #2 clk = ~clk;

    sram_phase_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cpu_edge(cpu_edge),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe), .sram_be_n(sram_be_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n)
    );

    // Asynchronous SRAM model: write on the rising write strobe.
    assign sram_dq_in = (!sram_oe_n) ? mem[sram_addr] : '0;
    always @(posedge sram_we_n) begin
        if (sram_dq_oe === 1'b1)
            for (int i = 0; i < BW; i++)
                if (!sram_be_n[i]) mem[sram_addr][8*i +: 8] <= sram_dq_out[8*i +: 8];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R4 monitor: outputs compared across each write pulse boundary.
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_dq;
    logic [BW-1:0] p_be;
    logic          p_oe, p_dqoe, p_we = 1'b1;
    always @(negedge clk) begin
        if (!rst && (!sram_we_n || !p_we)) begin
            check(sram_addr == p_addr && sram_dq_out == p_dq && sram_be_n == p_be
                  && sram_oe_n == p_oe && sram_dq_oe == p_dqoe,
                  "R4 stable around write", {sram_addr, sram_be_n}, {p_addr, p_be});
        end
        p_addr = sram_addr; p_dq = sram_dq_out; p_be = sram_be_n;
        p_oe = sram_oe_n; p_dqoe = sram_dq_oe; p_we = sram_we_n;
    end

    task automatic idle_chk(input string req);
        check(sram_we_n && sram_oe_n && !sram_dq_oe && (&sram_be_n), req,
              {sram_we_n, sram_oe_n, sram_dq_oe, sram_be_n}, {3'b110, {BW{1'b1}}});
    endtask

    // Called at a negedge; returns at the negedge inside phase 3.
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [BW-1:0] be);
        cpu_edge = 1'b1; req_valid = 1'b1; req_write = wr;
        req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        cpu_edge = 1'b0; req_valid = 1'b0;
        // phase 0
        check(sram_addr == a, "R2 addr in phase 0", sram_addr, a);
        check(sram_we_n == 1'b1, "R3 we high in phase 0", sram_we_n, 1);
        check(sram_be_n == ~be, "R9 byte strobes", sram_be_n, ~be);
        if (wr) begin
            check(sram_dq_oe && sram_oe_n, "R5 write drives bus", {sram_dq_oe, sram_oe_n}, 2'b11);
            check(sram_dq_out == d, "R5 write data", sram_dq_out, d);
        end else begin
            check(!sram_dq_oe && !sram_oe_n, "R6 read enables output", {sram_dq_oe, sram_oe_n}, 2'b00);
        end
        for (int k = 1; k <= 2; k++) begin
            @(negedge clk);
            check(sram_we_n == !wr, "R3 we in inner phase", sram_we_n, !wr);
            check(sram_oe_n == wr && sram_dq_oe == wr, "R5 R6 direction held",
                  {sram_oe_n, sram_dq_oe}, {wr, wr});
        end
        @(negedge clk);
        // phase 3
        check(sram_we_n == 1'b1, "R3 we high in phase 3", sram_we_n, 1);
        check(sram_addr == a, "R2 addr held in phase 3", sram_addr, a);
        if (wr) begin
            for (int i = 0; i < BW; i++)
                if (be[i]) model[a][8*i +: 8] = d[8*i +: 8];
        end else begin
            check(rd_data == model[a], "R7 read data", rd_data, model[a]);
        end
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = '0;
            model[i] = '0;
        end
        repeat (3) @(negedge clk);
        idle_chk("R1 reset idle");
        rst = 1'b0;
        @(negedge clk);
        idle_chk("R1 after reset");

        // Full-word writes then reads over every address.
        for (int a = 0; a < WORDS; a++)
            access(1'b1, AW'(a), DW'(16'hA5C3 ^ (a * 16'h1111)), '1);
        for (int a = 0; a < WORDS; a++)
            access(1'b0, AW'(a), '0, '1);

        // Byte-enable sweep, including no bytes selected (R9).
        for (int a = 0; a < WORDS; a++)
            access(1'b1, AW'(a), DW'(16'h3C00 + a * 16'h0107), BW'(a % 4));
        for (int a = 0; a < WORDS; a++)
            access(1'b0, AW'(a), '0, '1);

        // Idle gaps of different lengths before an access (R10, R8).
        for (int g = 1; g <= 3; g++) begin
            @(negedge clk);
            idle_chk("R8 no edge after phase 3");
            for (int k = 1; k < g; k++) @(negedge clk);
            access(1'b0, AW'(g + 4), '0, '1);
            check(rd_data == model[g + 4], "R10 access after gap", rd_data, model[g + 4]);
        end

        // CPU cycle without request (R8), read data hold (R7).
        access(1'b0, 4'd9, '0, '1);
        cpu_edge = 1'b1; req_valid = 1'b0; req_write = 1'b1; req_be = '1;
        @(negedge clk);
        cpu_edge = 1'b0;
        for (int k = 0; k < 4; k++) begin
            idle_chk("R8 empty CPU cycle");
            check(rd_data == model[9], "R7 read data held", rd_data, model[9]);
            @(negedge clk);
        end
        access(1'b0, 4'd9, '0, '1);
        check(mem[9] == model[9], "R8 memory untouched", mem[9], model[9]);
        @(negedge clk);
        idle_chk("R8 final idle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule